// File: doc/BRIEF.md
# Ethernet Receive Status Vector Generator

This block sits beside a receive MAC and watches the bytes of each incoming Ethernet frame. It keeps a running byte count and a running CRC. It captures the destination address, the type/length word and the first two bytes after it. It also collects per-frame error indications. When the frame's final byte arrives, it packs these observations into a single 32-bit status word. The word holds a byte count and a set of classification and error flags. The block then streams that word out as four bytes, least significant byte first. A buffer writer stores those bytes ahead of the frame, and software later reads them.

The frame stream uses three markers: a byte-valid strobe, a first-byte marker and a last-byte marker. The two markers are qualified by the valid strobe. Each frame is expected to carry at least 18 bytes.

The side inputs work as follows:
- The symbol-error input is collected over every byte of the frame.
- The extra-bits input is sampled together with the final byte.
- The long/drop and carrier inputs are pulses that can arrive at any time. They are remembered until the next frame ends, and that frame's vector reports them.

Top module: `rx_status_vector`

## Requirements
- R1: Bits 15:0 of the vector equal the number of valid bytes from the first-byte marker through the last-byte marker inclusive (addresses, type/length, payload, padding and FCS). The count saturates at 0xFFFF.
- R2: The vector is output in the four cycles that follow the cycle in which the last byte is accepted. `vecValid` is high for exactly those four cycles. `vecByte` carries bits 7:0, then 15:8, then 23:16, then 31:24.
- R3: The CRC check runs the reflected IEEE 802.3 CRC-32 over all bytes, FCS included, starting from all ones. The check passes when the final register matches the bit-reversed form of residue 0xC704DD7B. Bit 20 is set when the check fails. Bit 23 is set only when the check passes and no symbol error was flagged on any byte of the frame.
- R4: Bit 25 is set when the destination address is FF-FF-FF-FF-FF-FF. Bit 24 is set when bit 0 of the first destination byte is 1 and the address is not all ones.
- R5: Bit 22 is set when the type/length word (bytes 12 and 13, big-endian) exceeds 1500. When it is set, bit 21 is clear.
- R6: When the type/length word is 1500 or less, bit 21 is set if the payload byte count (total count minus 18) differs from that word. The comparison value is raised to 46 when the word is below 46, to allow for padding.
- R7: Bit 27 is set when the type is 0x8808. For such frames, bytes 14 and 15 form an opcode. Bit 28 is set when the opcode is 0x0001 and the destination is 01-80-C2-00-00-01. Bit 29 is set when the opcode is anything other than 0x0001.
- R8: Bit 30 is set when the type is 0x8100.
- R9: Bit 26 copies the extra-bits input sampled with the last byte.
- R10: Bit 16 is set if a long-event or drop pulse occurred since the previous frame end, up to and including the current last-byte cycle. Bit 18 reports carrier pulses over the same window. Both memories clear at each frame end.
- R11: Bits 31, 19 and 17 are always zero.
- R12: After reset, `vecValid` is low until a frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Frame byte valid |
| inStart | input | 1 | Current byte is the first of a frame |
| inEnd | input | 1 | Current byte is the last of a frame |
| inData | input | 8 | Frame byte |
| symErr | input | 1 | Symbol error on current byte |
| dribble | input | 1 | 1 to 7 stray bits after the final byte (with last byte) |
| longEvt | input | 1 | Long-event pulse |
| dropEvt | input | 1 | Dropped-frame pulse |
| carrierEvt | input | 1 | Carrier-event pulse |
| vecValid | output | 1 | Status byte valid |
| vecByte | output | 8 | Status byte, least significant first |

## Verification
Most state in this block is used only once, when the last byte arrives. A wrong running CRC, count or captured header byte therefore stays hidden during the frame. It first appears in the four bytes that follow the frame end. Errors in the sticky event memories or in the emission counter show up as well: a flag leaks into the next frame's vector, or `vecValid` runs one beat too long or too short. Those symptoms appear within one frame of the fault.

// File: rtl/rxsv_pkg.sv
package rxsv_pkg;

  typedef struct packed {
    logic first;   // accepted byte opens a frame
    logic take;    // a frame byte is accepted
    logic last;    // accepted byte closes a frame
    logic shift;   // advance the outgoing vector by one byte
  } rxsv_stb_t;

  localparam logic [31:0] CRC_POLY_REF = 32'hEDB88320;

  function automatic logic [31:0] crcStep(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int b = 0; b < 8; b++)
      r = (r[0] ^ d[b]) ? ((r >> 1) ^ CRC_POLY_REF) : (r >> 1);
    return r;
  endfunction

  function automatic logic [31:0] bitRev32(input logic [31:0] v);
    logic [31:0] r;
    for (int b = 0; b < 32; b++) r[b] = v[31-b];
    return r;
  endfunction

endpackage

// File: rtl/rxsv_ctrl.sv
module rxsv_ctrl
  import rxsv_pkg::*;
#(
  parameter int VEC_BYTES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inStart,
  input  logic       inEnd,
  output rxsv_stb_t  stb,
  output logic       vecValid
);
  localparam int EW = $clog2(VEC_BYTES + 1);

  logic [EW-1:0] emitCnt;

  always_comb begin
    stb.first = inValid & inStart;
    stb.take  = inValid;
    stb.last  = inValid & inEnd;
    stb.shift = (emitCnt != '0);
  end

  assign vecValid = (emitCnt != '0);

  always_ff @(posedge clk) begin
    if (!rstN)                emitCnt <= '0;
    else if (stb.last)        emitCnt <= EW'(VEC_BYTES);
    else if (emitCnt != '0)   emitCnt <= emitCnt - 1'b1;
  end

  // R2: a closing byte starts the emission in the next cycle
  a_r2_emit_follows_end: assert property (@(posedge clk) disable iff (!rstN)
    stb.last |=> vecValid);
  // R2: beat counter never exceeds the vector length
  a_r2_emit_bounded: assert property (@(posedge clk) disable iff (!rstN)
    emitCnt <= EW'(VEC_BYTES));
  // R12: nothing emitted without a preceding frame end
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!vecValid && !stb.last) |=> !vecValid);

endmodule

// File: rtl/rxsv_datapath.sv
module rxsv_datapath
  import rxsv_pkg::*;
#(
  parameter int          HDR_BYTES = 14,
  parameter int          FCS_BYTES = 4,
  parameter logic [15:0] MAX_LEN   = 16'd1500,
  parameter logic [15:0] MIN_DATA  = 16'd46,
  parameter logic [31:0] RESIDUE   = 32'hC704DD7B,
  parameter logic [15:0] CTRL_TYPE = 16'h8808,
  parameter logic [15:0] VLAN_TYPE = 16'h8100,
  parameter logic [15:0] PAUSE_OP  = 16'h0001,
  parameter logic [47:0] PAUSE_DA  = 48'h0180C2000001
) (
  input  logic       clk,
  input  logic       rstN,
  input  rxsv_stb_t  stb,
  input  logic [7:0] inData,
  input  logic       symErr,
  input  logic       dribble,
  input  logic       longEvt,
  input  logic       dropEvt,
  input  logic       carrierEvt,
  output logic [7:0] vecByte
);
  localparam int          DA_BYTES = 6;
  localparam logic [15:0] OVERHEAD = 16'(HDR_BYTES + FCS_BYTES);
  localparam logic [15:0] TL_HI    = 16'(HDR_BYTES - 2);
  localparam logic [15:0] TL_LO    = 16'(HDR_BYTES - 1);
  localparam logic [15:0] OP_HI    = 16'(HDR_BYTES);
  localparam logic [15:0] OP_LO    = 16'(HDR_BYTES + 1);
  localparam logic [31:0] RES_REF  = bitRev32(RESIDUE);

  logic [15:0] byteCnt, idx, cntNext;
  logic [47:0] daReg;
  logic [15:0] tlReg, opReg;
  logic [31:0] crcReg, crcNext;
  logic        symSeen, symNow;
  logic        stickyLong, stickyCar;
  logic [31:0] vecReg, vecNext;

  // per-byte position and running values
  always_comb begin
    idx     = stb.first ? 16'd0 : byteCnt;
    cntNext = (idx == 16'hFFFF) ? idx : idx + 16'd1;
    crcNext = crcStep(stb.first ? 32'hFFFFFFFF : crcReg, inData);
    symNow  = (stb.first ? 1'b0 : symSeen) | symErr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCnt <= '0;
      daReg   <= '0;
      tlReg   <= '0;
      opReg   <= '0;
      crcReg  <= '1;
      symSeen <= 1'b0;
    end else if (stb.take) begin
      byteCnt <= cntNext;
      crcReg  <= crcNext;
      symSeen <= symNow;
      for (int k = 0; k < DA_BYTES; k++)
        if (idx == 16'(k)) daReg[8*(DA_BYTES-1-k) +: 8] <= inData;
      if (idx == TL_HI) tlReg[15:8] <= inData;
      if (idx == TL_LO) tlReg[7:0]  <= inData;
      if (idx == OP_HI) opReg[15:8] <= inData;
      if (idx == OP_LO) opReg[7:0]  <= inData;
    end
  end

  // events remembered between frame ends
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stickyLong <= 1'b0;
      stickyCar  <= 1'b0;
    end else if (stb.last) begin
      stickyLong <= 1'b0;
      stickyCar  <= 1'b0;
    end else begin
      stickyLong <= stickyLong | longEvt | dropEvt;
      stickyCar  <= stickyCar | carrierEvt;
    end
  end

  // classification of the completed frame
  logic        isCtrl, pauseDa, pauseOp, isBcast, isMcast, crcGood, outRange, lenErr;
  logic [15:0] dataBytes, expData;

  always_comb begin
    isCtrl    = (tlReg == CTRL_TYPE);
    pauseDa   = (daReg == PAUSE_DA);
    pauseOp   = (opReg == PAUSE_OP);
    isBcast   = &daReg;
    isMcast   = daReg[40] & ~isBcast;
    crcGood   = (crcNext == RES_REF);
    outRange  = (tlReg > MAX_LEN);
    dataBytes = cntNext - OVERHEAD;
    expData   = (tlReg < MIN_DATA) ? MIN_DATA : tlReg;
    lenErr    = ~outRange & ((cntNext < OVERHEAD) | (dataBytes != expData));
    vecNext   = {1'b0, (tlReg == VLAN_TYPE), isCtrl & ~pauseOp,
                 isCtrl & pauseOp & pauseDa, isCtrl, dribble, isBcast, isMcast,
                 crcGood & ~symNow, outRange, lenErr, ~crcGood, 1'b0,
                 stickyCar | carrierEvt, 1'b0, stickyLong | longEvt | dropEvt,
                 cntNext};
  end

  always_ff @(posedge clk) begin
    if (!rstN)          vecReg <= '0;
    else if (stb.last)  vecReg <= vecNext;
    else if (stb.shift) vecReg <= {8'h00, vecReg[31:8]};
  end

  assign vecByte = vecReg[7:0];

  // R4: broadcast and multicast never reported together
  a_r4_cast_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    stb.last |=> !(vecReg[25] && vecReg[24]));
  // R7: pause implies control frame, and excludes unknown opcode
  a_r7_pause_is_ctrl: assert property (@(posedge clk) disable iff (!rstN)
    stb.last |=> ((!vecReg[28] || vecReg[27]) && !(vecReg[28] && vecReg[29])));
  // R3: good frame and CRC error are exclusive
  a_r3_ok_vs_crc: assert property (@(posedge clk) disable iff (!rstN)
    stb.last |=> !(vecReg[23] && vecReg[20]));
  // R5: out-of-range type disables the length check
  a_r5_range_vs_len: assert property (@(posedge clk) disable iff (!rstN)
    stb.last |=> !(vecReg[22] && vecReg[21]));
  // R1: a completed frame always has a nonzero count
  a_r1_count_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    stb.last |=> (vecReg[15:0] != 16'd0));

endmodule

// File: rtl/rx_status_vector.sv
module rx_status_vector
  import rxsv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inStart,
  input  logic       inEnd,
  input  logic [7:0] inData,
  input  logic       symErr,
  input  logic       dribble,
  input  logic       longEvt,
  input  logic       dropEvt,
  input  logic       carrierEvt,
  output logic       vecValid,
  output logic [7:0] vecByte
);
  rxsv_stb_t stb;

  rxsv_ctrl #(.VEC_BYTES(4)) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inStart(inStart),
    .inEnd(inEnd), .stb(stb), .vecValid(vecValid)
  );

  rxsv_datapath uData (
    .clk(clk), .rstN(rstN), .stb(stb), .inData(inData), .symErr(symErr),
    .dribble(dribble), .longEvt(longEvt), .dropEvt(dropEvt),
    .carrierEvt(carrierEvt), .vecByte(vecByte)
  );

endmodule

// File: tb/rx_status_vector_test.sv
module rx_status_vector_test;
  logic clk = 1'b0, rstN = 1'b0;
  logic inValid = 0, inStart = 0, inEnd = 0, symErr = 0, dribble = 0;
  logic longEvt = 0, dropEvt = 0, carrierEvt = 0;
  logic [7:0] inData = 0;
  logic vecValid;
  logic [7:0] vecByte;

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] frm[$];

  // flag positions in the upper half (bit n of vector -> n-16)
  localparam logic [15:0] F_LONG = 16'h0001, F_CAR = 16'h0004, F_CRC = 16'h0010,
    F_LEN = 16'h0020, F_RNG = 16'h0040, F_OK = 16'h0080, F_MC = 16'h0100,
    F_BC = 16'h0200, F_DRB = 16'h0400, F_CTL = 16'h0800, F_PAU = 16'h1000,
    F_UNK = 16'h2000, F_VLN = 16'h4000;
  localparam logic [47:0] UNI = 48'h021122334455, PDA = 48'h0180C2000001;

  rx_status_vector uut (.*);

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] fcsOf();
    logic [31:0] c = 32'hFFFFFFFF;
    foreach (frm[i])
      for (int b = 0; b < 8; b++)
        c = ((c[0] ^ frm[i][b]) != 0) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    return ~c;
  endfunction

  task automatic build(input logic [47:0] da, input logic [15:0] tl,
                       input int nData, input int opc, input bit badCrc);
    logic [31:0] f;
    frm.delete();
    for (int k = 0; k < 6; k++) frm.push_back(da[8*(5-k) +: 8]);
    for (int k = 0; k < 6; k++) frm.push_back(8'h60 + 8'(k));
    frm.push_back(tl[15:8]);
    frm.push_back(tl[7:0]);
    for (int k = 0; k < nData; k++) begin
      if (opc >= 0 && k == 0)      frm.push_back(8'(opc >> 8));
      else if (opc >= 0 && k == 1) frm.push_back(8'(opc));
      else                         frm.push_back(8'(k) ^ 8'h5A);
    end
    f = fcsOf();
    if (badCrc) f[3] = ~f[3];
    for (int k = 0; k < 4; k++) frm.push_back(f[8*k +: 8]);
  endtask

  task automatic runFrame(input string req, input logic [15:0] expFlags,
                          input int symAt, input int carAt, input int dropAt, input bit drib);
    logic [31:0] word;
    logic [15:0] expCnt;
    int last = frm.size() - 1;
    expCnt = (frm.size() > 65535) ? 16'hFFFF : 16'(frm.size());
    for (int i = 0; i <= last; i++) begin
      @(negedge clk);
      inValid = 1; inStart = (i == 0); inEnd = (i == last); inData = frm[i];
      symErr = (i == symAt); carrierEvt = (i == carAt); dropEvt = (i == dropAt);
      dribble = (i == last) && drib;
    end
    @(negedge clk);
    inValid = 0; inStart = 0; inEnd = 0; symErr = 0; carrierEvt = 0; dropEvt = 0; dribble = 0;
    for (int b = 0; b < 4; b++) begin
      if (b > 0) @(negedge clk);
      check("R2 valid beat", 32'(vecValid), 32'd1);
      word[8*b +: 8] = vecByte;
    end
    @(negedge clk);
    check("R2 valid ends", 32'(vecValid), 32'd0);
    check("R11 zero bits", {29'd0, word[31], word[19], word[17]}, 32'd0);
    check({req, " vector"}, word, {expFlags, expCnt});
  endtask

  task automatic tUnicastGood();  build(UNI, 16'd46, 46, -1, 0); runFrame("R1 R3 R6", F_OK, -1, -1, -1, 0); endtask
  task automatic tBadCrc();       build(UNI, 16'd46, 46, -1, 1); runFrame("R3 crc", F_CRC, -1, -1, -1, 0); endtask
  task automatic tSymbol();       build(UNI, 16'd46, 46, -1, 0); runFrame("R3 symbol", 16'h0, 20, -1, -1, 0); endtask
  task automatic tBroadcast();    build(48'hFFFFFFFFFFFF, 16'h0800, 50, -1, 0); runFrame("R4 R5 bcast", F_BC | F_OK | F_RNG, -1, -1, -1, 0); endtask
  task automatic tMulticastPad(); build(48'h01005E000007, 16'd10, 46, -1, 0); runFrame("R4 R6 mcast pad", F_MC | F_OK, -1, -1, -1, 0); endtask
  task automatic tLenMismatch();  build(UNI, 16'd100, 60, -1, 0); runFrame("R6 mismatch", F_LEN | F_OK, -1, -1, -1, 0); endtask
  task automatic tShortNoPad();   build(UNI, 16'd10, 10, -1, 0); runFrame("R6 unpadded", F_LEN | F_OK, -1, -1, -1, 0); endtask
  task automatic tPause();        build(PDA, 16'h8808, 46, 1, 0); runFrame("R7 pause", F_MC | F_CTL | F_PAU | F_OK | F_RNG, -1, -1, -1, 0); endtask
  task automatic tUnknownOp();    build(PDA, 16'h8808, 46, 5, 0); runFrame("R7 unknown", F_MC | F_CTL | F_UNK | F_OK | F_RNG, -1, -1, -1, 0); endtask
  task automatic tCtrlWrongDa();  build(UNI, 16'h8808, 46, 1, 0); runFrame("R7 wrong da", F_CTL | F_OK | F_RNG, -1, -1, -1, 0); endtask
  task automatic tVlan();         build(UNI, 16'h8100, 50, -1, 0); runFrame("R8 vlan", F_VLN | F_OK | F_RNG, -1, -1, -1, 0); endtask
  task automatic tDribble();      build(UNI, 16'd46, 46, -1, 0); runFrame("R9 dribble", F_DRB | F_OK, -1, -1, -1, 1); endtask

  task automatic tSticky();
    @(negedge clk); longEvt = 1;
    @(negedge clk); longEvt = 0;
    repeat (3) @(negedge clk);
    build(UNI, 16'd46, 46, -1, 0); runFrame("R10 sticky set", F_LONG | F_CAR | F_OK, -1, 5, -1, 0);
    build(UNI, 16'd46, 46, -1, 0); runFrame("R10 sticky cleared", F_OK, -1, -1, -1, 0);
    build(UNI, 16'd46, 46, -1, 0); runFrame("R10 drop", F_LONG | F_OK, -1, -1, 30, 0);
  endtask

  task automatic tSaturate();     build(UNI, 16'h0800, 65522, -1, 0); runFrame("R1 saturate", F_OK | F_RNG, -1, -1, -1, 0); endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R12 reset valid", 32'(vecValid), 32'd0);
    rstN = 1;
    repeat (2) @(negedge clk);
    check("R12 idle valid", 32'(vecValid), 32'd0);
    tUnicastGood();
    tBadCrc();
    tSymbol();
    tBroadcast();
    tMulticastPad();
    tLenMismatch();
    tShortNoPad();
    tPause();
    tUnknownOp();
    tCtrlWrongDa();
    tVlan();
    tDribble();
    tSticky();
    tSaturate();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule